// File: doc/BRIEF.md
# Boundary-Scan Register Chain

This block is the boundary-scan data register of a test access port. It stands between a chip's core logic and its pads for a configurable number of output pins and input pins. Each output pin carries two serial cells and each input pin carries one. The cells form a single shift path from the serial input to the serial output. The test controller drives three one-cycle strobes, capture, shift and update, and four decoded instruction selects: external test, sample/preload, clamp and high-impedance. These move values between the pins, the shift cells and a bank of update latches, and decide whether the pads follow the core or the latches.

With no instruction selected, the block is a plain pass-through. Under sample/preload the core keeps the pads while the chain records them or is loaded ahead of time. Under external test the latched values drive the pads and feed the core inputs. Under clamp the latched values stay on the pads and the chain does not move; the one-bit bypass path elsewhere carries the scan traffic. Under high-impedance every output enable is off.

Top module: `boundary_scan_chain`

## Requirements
- R1: The chain has 2*N_OUT+N_IN cells, numbered from 0 at the serial output. Cells 0 to N_IN-1 belong to input pins 0 to N_IN-1. For output pin p, cell N_IN+2p is the enable and cell N_IN+2p+1 is the data, so the data cell is nearer the serial input. While shift_dr is high and the chain is active, every cell takes the value of its neighbour toward the serial input, the last cell takes tdi, and tdo always shows cell 0.
- R2: On capture_dr, while the chain is active, each output pin's data cell loads core_out, its enable cell loads core_oe, and each input cell loads pin_in. Capture takes precedence over shift in the same cycle.
- R3: On update_dr, while the chain is active, the update latches copy the shift cells. Under external test, pin_out, pin_oe and core_in come from the latches.
- R4: The latches change only on update_dr, so the pads stay still while the chain shifts.
- R5: Under sample/preload, pin_out equals core_out, pin_oe equals core_oe and core_in equals pin_in, while capture, shift and update all still work. This lets the latches be preloaded before external test.
- R6: Under clamp, the pads and core_in come from the latches. Capture, shift and update have no effect.
- R7: Under high-impedance, every bit of pin_oe is 0, pin_out follows core_out, and the strobes have no effect.
- R8: With no select high, the pads follow the core, core_in follows pin_in, and the strobes have no effect.
- R9: Synchronous active-high rst clears every shift cell and every latch.
- R10: When several selects are high at once, the mode is chosen in this order: high-impedance first, then clamp, then external test, then sample/preload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe |
| sel_extest | input | 1 | External test selected |
| sel_sample | input | 1 | Sample/preload selected |
| sel_clamp | input | 1 | Clamp selected |
| sel_highz | input | 1 | High-impedance selected |
| tdi | input | 1 | Serial input |
| tdo | output | 1 | Serial output, cell 0 |
| core_out | input | N_OUT | Output data from core |
| core_oe | input | N_OUT | Output enable from core (1 drives) |
| pin_out | output | N_OUT | Output data to pads |
| pin_oe | output | N_OUT | Output enable to pads (1 drives) |
| pin_in | input | N_IN | Input values from pads |
| core_in | output | N_IN | Input values to core |

## Verification
The hardest thing to observe from the ports is that a strobe had no effect under clamp, high-impedance or no instruction. The shift cells are hidden, and the pads do not show them in those modes. To expose them, the bench first loads a known word, then applies capture, shift and update in the idle mode. It then changes to sample/preload and shifts the chain out, so the unchanged word appears on tdo. A second hard case is the check that the pads stay still while the chain shifts. For this the bench loads every one of the 64 chain words of a two-output, two-input setup under external test. It compares the pads to the previous word after shifting and before each update.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    typedef enum logic [2:0] {
        MODE_FUNC,
        MODE_SAMPLE,
        MODE_EXTEST,
        MODE_CLAMP,
        MODE_HIGHZ
    } bsr_mode_e;

    typedef struct packed {
        logic chain_en;     // strobes act on the chain
        logic drive_latch;  // pads and core inputs taken from latches
        logic force_off;    // all output enables forced low
    } bsr_ctrl_t;

    function automatic int bsr_len(input int n_out, input int n_in);
        return 2 * n_out + n_in;
    endfunction

    function automatic int bsr_oe_idx(input int n_in, input int p);
        return n_in + 2 * p;
    endfunction

    function automatic int bsr_data_idx(input int n_in, input int p);
        return n_in + 2 * p + 1;
    endfunction

    function automatic bsr_mode_e bsr_decode(input logic ext, input logic smp,
                                             input logic clp, input logic hz);
        if (hz)       return MODE_HIGHZ;
        else if (clp) return MODE_CLAMP;
        else if (ext) return MODE_EXTEST;
        else if (smp) return MODE_SAMPLE;
        else          return MODE_FUNC;
    endfunction

    function automatic bsr_ctrl_t bsr_ctrl(input bsr_mode_e m);
        bsr_ctrl_t c;
        c = '0;
        case (m)
            MODE_SAMPLE: c.chain_en = 1'b1;
            MODE_EXTEST: begin c.chain_en = 1'b1; c.drive_latch = 1'b1; end
            MODE_CLAMP:  c.drive_latch = 1'b1;
            MODE_HIGHZ:  c.force_off = 1'b1;
            default:     c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/bsr_shift_stage.sv
module bsr_shift_stage #(
    parameter int LEN = 12
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cap_en,
    input  logic           shift_en,
    input  logic [LEN-1:0] cap_vec,
    input  logic           tdi,
    output logic [LEN-1:0] sr
);
    generate
        if (LEN > 1) begin : g_multi
            always_ff @(posedge clk) begin
                if (rst)           sr <= '0;
                else if (cap_en)   sr <= cap_vec;
                else if (shift_en) sr <= {tdi, sr[LEN-1:1]};
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst)           sr <= '0;
                else if (cap_en)   sr <= cap_vec;
                else if (shift_en) sr <= tdi;
            end
        end
    endgenerate
endmodule

// File: rtl/bsr_update_latch.sv
module bsr_update_latch #(
    parameter int LEN = 12
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           upd_en,
    input  logic [LEN-1:0] d,
    output logic [LEN-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)         q <= '0;
        else if (upd_en) q <= d;
    end
endmodule

// File: rtl/bsr_pin_mux.sv
module bsr_pin_mux
    import bsr_pkg::*;
#(
    parameter int N_OUT = 4,
    parameter int N_IN  = 4,
    localparam int LEN  = bsr_len(N_OUT, N_IN)
) (
    input  bsr_ctrl_t        ctrl,
    input  logic [LEN-1:0]   lat,
    input  logic [N_OUT-1:0] core_out,
    input  logic [N_OUT-1:0] core_oe,
    input  logic [N_IN-1:0]  pin_in,
    output logic [N_OUT-1:0] pin_out,
    output logic [N_OUT-1:0] pin_oe,
    output logic [N_IN-1:0]  core_in,
    output logic [LEN-1:0]   cap_vec
);
    for (genvar k = 0; k < N_IN; k++) begin : g_in
        assign cap_vec[k] = pin_in[k];
        assign core_in[k] = ctrl.drive_latch ? lat[k] : pin_in[k];
    end

    for (genvar p = 0; p < N_OUT; p++) begin : g_out
        localparam int OE_I = bsr_oe_idx(N_IN, p);
        localparam int D_I  = bsr_data_idx(N_IN, p);
        assign cap_vec[OE_I] = core_oe[p];
        assign cap_vec[D_I]  = core_out[p];
        assign pin_out[p]    = ctrl.drive_latch ? lat[D_I] : core_out[p];
        assign pin_oe[p]     = ctrl.force_off   ? 1'b0
                             : (ctrl.drive_latch ? lat[OE_I] : core_oe[p]);
    end
endmodule

// File: rtl/boundary_scan_chain.sv
module boundary_scan_chain
    import bsr_pkg::*;
#(
    parameter int N_OUT = 4,
    parameter int N_IN  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture_dr,
    input  logic             shift_dr,
    input  logic             update_dr,
    input  logic             sel_extest,
    input  logic             sel_sample,
    input  logic             sel_clamp,
    input  logic             sel_highz,
    input  logic             tdi,
    output logic             tdo,
    input  logic [N_OUT-1:0] core_out,
    input  logic [N_OUT-1:0] core_oe,
    output logic [N_OUT-1:0] pin_out,
    output logic [N_OUT-1:0] pin_oe,
    input  logic [N_IN-1:0]  pin_in,
    output logic [N_IN-1:0]  core_in
);
    localparam int LEN = bsr_len(N_OUT, N_IN);

    bsr_mode_e      mode;
    bsr_ctrl_t      ctrl;
    logic [LEN-1:0] sr_q;
    logic [LEN-1:0] lat_q;
    logic [LEN-1:0] cap_vec;

    assign mode = bsr_decode(sel_extest, sel_sample, sel_clamp, sel_highz);
    assign ctrl = bsr_ctrl(mode);
    assign tdo  = sr_q[0];

    bsr_shift_stage #(.LEN(LEN)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .cap_en   (ctrl.chain_en & capture_dr),
        .shift_en (ctrl.chain_en & shift_dr),
        .cap_vec  (cap_vec),
        .tdi      (tdi),
        .sr       (sr_q)
    );

    bsr_update_latch #(.LEN(LEN)) u_latch (
        .clk    (clk),
        .rst    (rst),
        .upd_en (ctrl.chain_en & update_dr),
        .d      (sr_q),
        .q      (lat_q)
    );

    bsr_pin_mux #(.N_OUT(N_OUT), .N_IN(N_IN)) u_mux (
        .ctrl     (ctrl),
        .lat      (lat_q),
        .core_out (core_out),
        .core_oe  (core_oe),
        .pin_in   (pin_in),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe),
        .core_in  (core_in),
        .cap_vec  (cap_vec)
    );
endmodule

// File: rtl/bsr_checker.sv
module bsr_checker #(
    parameter int N_OUT = 4,
    parameter int N_IN  = 4,
    localparam int LEN  = 2 * N_OUT + N_IN
) (
    input logic             clk,
    input logic             rst,
    input logic             capture_dr,
    input logic             shift_dr,
    input logic             update_dr,
    input logic             sel_extest,
    input logic             sel_sample,
    input logic             sel_clamp,
    input logic             sel_highz,
    input logic             tdi,
    input logic [N_OUT-1:0] core_out,
    input logic [N_OUT-1:0] core_oe,
    input logic [N_OUT-1:0] pin_out,
    input logic [N_OUT-1:0] pin_oe,
    input logic [N_IN-1:0]  pin_in,
    input logic [N_IN-1:0]  core_in,
    input logic [LEN-1:0]   sr
);
    logic active;
    logic ext_only;
    logic smp_only;
    assign active   = (sel_extest | sel_sample) & ~sel_clamp & ~sel_highz;
    assign ext_only = sel_extest & ~sel_clamp & ~sel_highz;
    assign smp_only = sel_sample & ~sel_extest & ~sel_clamp & ~sel_highz;

    // R1
    shift_move_chk: assert property (@(posedge clk) disable iff (rst)
        (active && shift_dr && !capture_dr) |=>
            (sr == {$past(tdi), $past(sr[LEN-1:1])}));

    // R4
    pad_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ext_only && !update_dr) |=>
            (!ext_only || ($stable(pin_out) && $stable(pin_oe) && $stable(core_in))));

    // R5
    sample_pass_chk: assert property (@(posedge clk) disable iff (rst)
        smp_only |-> (pin_out == core_out && pin_oe == core_oe && core_in == pin_in));

    // R7
    highz_off_chk: assert property (@(posedge clk) disable iff (rst)
        sel_highz |-> (pin_oe == '0));

    // R6
    idle_chain_chk: assert property (@(posedge clk) disable iff (rst)
        !active |=> $stable(sr));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (sr == '0));
endmodule

bind boundary_scan_chain bsr_checker #(.N_OUT(N_OUT), .N_IN(N_IN)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .update_dr  (update_dr),
    .sel_extest (sel_extest),
    .sel_sample (sel_sample),
    .sel_clamp  (sel_clamp),
    .sel_highz  (sel_highz),
    .tdi        (tdi),
    .core_out   (core_out),
    .core_oe    (core_oe),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .pin_in     (pin_in),
    .core_in    (core_in),
    .sr         (sr_q)
);

// File: tb/sim_boundary_scan_chain.sv
module sim_boundary_scan_chain;
    localparam int NO = 2;
    localparam int NI = 2;
    localparam int L  = 2 * NO + NI;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic capture_dr = 0, shift_dr = 0, update_dr = 0;
    logic sel_extest = 0, sel_sample = 0, sel_clamp = 0, sel_highz = 0;
    logic tdi = 0;
    logic tdo;
    logic [NO-1:0] core_out = '0, core_oe = '0, pin_out, pin_oe;
    logic [NI-1:0] pin_in = '0, core_in;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    boundary_scan_chain #(.N_OUT(NO), .N_IN(NI)) u0 (
        .clk(clk), .rst(rst), .capture_dr(capture_dr), .shift_dr(shift_dr),
        .update_dr(update_dr), .sel_extest(sel_extest), .sel_sample(sel_sample),
        .sel_clamp(sel_clamp), .sel_highz(sel_highz), .tdi(tdi), .tdo(tdo),
        .core_out(core_out), .core_oe(core_oe), .pin_out(pin_out), .pin_oe(pin_oe),
        .pin_in(pin_in), .core_in(core_in)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // field helpers, from the cell order in R1
    function automatic logic [NO-1:0] f_data(input logic [L-1:0] v);
        logic [NO-1:0] r;
        for (int p = 0; p < NO; p++) r[p] = v[NI + 2 * p + 1];
        return r;
    endfunction
    function automatic logic [NO-1:0] f_oe(input logic [L-1:0] v);
        logic [NO-1:0] r;
        for (int p = 0; p < NO; p++) r[p] = v[NI + 2 * p];
        return r;
    endfunction
    function automatic logic [L-1:0] mk_vec(input logic [NO-1:0] d, input logic [NO-1:0] e,
                                             input logic [NI-1:0] i);
        logic [L-1:0] v;
        for (int k = 0; k < NI; k++) v[k] = i[k];
        for (int p = 0; p < NO; p++) begin
            v[NI + 2 * p]     = e[p];
            v[NI + 2 * p + 1] = d[p];
        end
        return v;
    endfunction

    task automatic set_mode(input logic e, input logic s, input logic c, input logic h);
        sel_extest = e; sel_sample = s; sel_clamp = c; sel_highz = h;
        @(negedge clk);
    endtask
    task automatic shift_word(input logic [L-1:0] din, output logic [L-1:0] dout);
        for (int i = 0; i < L; i++) begin
            dout[i] = tdo;
            tdi = din[i];
            shift_dr = 1'b1;
            @(negedge clk);
        end
        shift_dr = 1'b0;
    endtask
    task automatic pulse_cap();
        capture_dr = 1'b1; @(negedge clk); capture_dr = 1'b0;
    endtask
    task automatic pulse_upd();
        update_dr = 1'b1; @(negedge clk); update_dr = 1'b0;
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [L-1:0] dout;
        logic [L-1:0] prev;
        logic [L-1:0] pat;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9: reset clears latches and cells
        set_mode(1, 0, 0, 0);
        chk("R9 pin_oe", pin_oe, 0);
        chk("R9 pin_out", pin_out, 0);
        chk("R9 core_in", core_in, 0);
        chk("R9 tdo", tdo, 0);

        // R3/R4: every chain word under external test
        prev = '0;
        for (int v = 0; v < (1 << L); v++) begin
            shift_word(L'(v), dout);
            chk("R4 hold pin_out", pin_out, f_data(prev));
            chk("R4 hold pin_oe", pin_oe, f_oe(prev));
            chk("R1 shift-out prior word", dout, prev);
            pulse_upd();
            chk("R3 pin_out", pin_out, f_data(L'(v)));
            chk("R3 pin_oe", pin_oe, f_oe(L'(v)));
            chk("R3 core_in", core_in, L'(v) & ((1 << NI) - 1));
            prev = L'(v);
        end

        // R2/R5: capture sweep under sample/preload
        set_mode(0, 1, 0, 0);
        for (int v = 0; v < (1 << L); v++) begin
            core_out = v[1:0]; core_oe = v[3:2]; pin_in = v[5:4];
            @(negedge clk);
            chk("R5 pin_out", pin_out, core_out);
            chk("R5 pin_oe", pin_oe, core_oe);
            chk("R5 core_in", core_in, pin_in);
            pulse_cap();
            shift_word('0, dout);
            chk("R2 captured word", dout, mk_vec(core_out, core_oe, pin_in));
        end

        // R5: preload then switch to external test
        core_out = 2'b01; core_oe = 2'b10; pin_in = 2'b11;
        pat = 6'b101101;
        shift_word(pat, dout);
        pulse_upd();
        chk("R5 preload keeps core pads", pin_out, 2'b01);
        set_mode(1, 0, 0, 0);
        chk("R5 preload visible out", pin_out, f_data(pat));
        chk("R5 preload visible oe", pin_oe, f_oe(pat));

        // R6: clamp holds latches, strobes ignored
        set_mode(0, 0, 1, 0);
        chk("R6 clamp pin_out", pin_out, f_data(pat));
        chk("R6 clamp core_in", core_in, pat[1:0]);
        pulse_cap();
        shift_word(6'b010010, dout);
        pulse_upd();
        chk("R6 clamp pads unchanged", {pin_out, pin_oe}, {f_data(pat), f_oe(pat)});
        set_mode(0, 1, 0, 0);
        shift_word(pat, dout);
        chk("R6 clamp chain unchanged", dout, pat);

        // R7: high-impedance
        pat = 6'b111100;
        shift_word(pat, dout);
        pulse_upd();
        core_out = 2'b10; core_oe = 2'b11;
        set_mode(0, 0, 0, 1);
        chk("R7 oe forced off", pin_oe, 0);
        chk("R7 pin_out follows core", pin_out, 2'b10);
        pulse_cap();
        shift_word(6'b000011, dout);
        pulse_upd();
        set_mode(0, 1, 0, 0);
        shift_word(pat, dout);
        chk("R7 chain unchanged", dout, pat);

        // R8: no instruction
        set_mode(0, 0, 0, 0);
        pin_in = 2'b01;
        @(negedge clk);
        chk("R8 pads follow core", {pin_out, pin_oe}, {core_out, core_oe});
        chk("R8 core_in follows pin", core_in, 2'b01);
        pulse_cap();
        shift_word(6'b010101, dout);
        pulse_upd();
        set_mode(1, 0, 0, 0);
        chk("R8 latches unchanged", {pin_out, pin_oe}, {f_data(pat), f_oe(pat)});
        set_mode(0, 1, 0, 0);
        shift_word(pat, dout);
        chk("R8 chain unchanged", dout, pat);

        // R10: priority
        set_mode(1, 0, 0, 1);
        chk("R10 highz over extest", pin_oe, 0);
        set_mode(1, 0, 1, 0);
        shift_word(6'b000000, dout);
        chk("R10 clamp over extest holds chain", dout, 0);
        set_mode(1, 1, 0, 0);
        chk("R10 extest over sample", {pin_out, pin_oe}, {f_data(pat), f_oe(pat)});
        set_mode(0, 1, 0, 0);
        shift_word(6'b000000, dout);
        chk("R10 clamp left chain intact", dout, pat);

        done = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule